// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard controller for a small out-of-order execution core. Decoded instructions arrive one at a time, in program order. The controller decides whether each one may issue. Once an instruction has issued, the controller decides when its functional unit may read operands from the register file, and when that unit may write its result back. It keeps two tables:

- a status entry for every functional unit;
- a map that records which unit will next write each register.

Hazards are resolved only by waiting. No result is forwarded between units and no register is renamed:

- a write-after-write conflict stalls issue;
- a read-after-write dependence keeps a unit in its operand-read phase;
- a write-after-read conflict holds back the result write.

The units themselves, the register storage and branch handling are outside the block. Each unit reports the end of its execution with a one-cycle pulse. In return it receives a read grant and a write permit.

Top module: `sb_scoreboard`

## Requirements
- R1: Units are numbered by kind: integer units first, then multiply, then add, then divide. With the default sizes these are unit 0 (integer), units 1 and 2 (multiply), unit 3 (add) and unit 4 (divide).
  - The op code picks the kind: 1 selects multiply, 2 and 3 select add, 4 selects divide, and any other value selects integer.
  - `instAccept` is high only when `instValid` is high and a unit of that kind is idle. The lowest-numbered idle unit of the kind receives the instruction.
  - At most one instruction issues per cycle.
- R2: Issue stalls (`instAccept` low) while the destination register is still the pending destination of an issued instruction that has not yet written. Issue resumes in the cycle after that write.
- R3: `readGrant` for a unit is high only while that unit waits to read and both of its source operands are ready. A source produced by an outstanding unit becomes ready in the cycle after that unit's write permit.
- R4: A unit enters execution on the clock edge after its read grant. An `execDone` pulse on an executing unit raises its write request, and the request is visible in the following cycle. A pulse on a unit that is idle or still waiting for operands has no effect.
- R5: A unit's write permit is withheld while any other unit is still waiting to read, has its ready flag set, and names the writer's destination register as one of its sources.
- R6: `writePermit` is at most one-hot. When several units may write in the same cycle, the lowest-numbered unit is permitted first.
- R7: A permitted write does three things at the clock edge:
  - it frees the unit;
  - it clears the register map entry;
  - it marks ready every waiting source operand that named this unit as its producer.
- R8: An instruction that issues in the same cycle as the write permit of the producer of one of its sources treats that source as already ready.
- R9: During and directly after reset, no unit is busy, `readGrant` and `writePermit` are all zero, and every register is free of pending writers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | A decoded instruction is offered |
| instOp | input | 3 | Op code; selects the unit kind |
| instDst | input | 4 | Destination register |
| instSrcJ | input | 4 | First source register |
| instSrcK | input | 4 | Second source register |
| instAccept | output | 1 | The offered instruction issues at this clock edge |
| readGrant | output | 5 | Per-unit permission to read operands this cycle |
| execDone | input | 5 | Per-unit end-of-execution pulse |
| writePermit | output | 5 | Per-unit permission to write the result this cycle |

## Verification
Two functions can fall in the same cycle: a result write, and the issue of an instruction that reads the register being written. The bench provokes this by offering an integer instruction whose sources are the multiply unit's destination, in the very cycle that the multiply unit holds its write permit. The case is judged by whether the new unit is granted its operand read in the next cycle rather than waiting for a broadcast that already happened. The bench also lines up a finished writer against a waiting reader of the same register, and lets all units finish in one cycle so that the lowest-index write ordering can be observed.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Index width for functional units; the design supports up to 8 units.
  localparam int unsigned FU_IW = 3;

  typedef enum logic [1:0] {
    KIND_INT = 2'd0,
    KIND_MUL = 2'd1,
    KIND_ADD = 2'd2,
    KIND_DIV = 2'd3
  } fuKind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_EXEC  = 2'd2,
    PH_WRITE = 2'd3
  } fuPhase_e;

  // Strobes from control to the status tables.
  typedef struct packed {
    logic             issueEn;
    logic [FU_IW-1:0] issueFu;
    logic             wrEn;
    logic [FU_IW-1:0] wrFu;
  } sbStrobe_t;

  function automatic fuKind_e opKind(input logic [2:0] op);
    case (op)
      3'd1:       opKind = KIND_MUL;
      3'd2, 3'd3: opKind = KIND_ADD;
      3'd4:       opKind = KIND_DIV;
      default:    opKind = KIND_INT;
    endcase
  endfunction

endpackage

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int unsigned NUM_FU   = 5,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sbStrobe_t        strobe,
  input  logic [NUM_FU-1:0] readGo,
  input  logic [NUM_FU-1:0] doneGo,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrcJ,
  input  logic [REG_W-1:0] instSrcK,
  output fuPhase_e         phase [NUM_FU],
  output logic [REG_W-1:0] fi [NUM_FU],
  output logic [REG_W-1:0] fj [NUM_FU],
  output logic [REG_W-1:0] fk [NUM_FU],
  output logic [NUM_FU-1:0] rj,
  output logic [NUM_FU-1:0] rk,
  output logic [NUM_REGS-1:0] mapValid,
  output logic [FU_IW-1:0] mapFu [NUM_REGS]
);

  logic [FU_IW-1:0] qj [NUM_FU];
  logic [FU_IW-1:0] qk [NUM_FU];
  logic [NUM_FU-1:0] qjValid;
  logic [NUM_FU-1:0] qkValid;

  // Source pending at issue, with bypass of the producer writing this cycle.
  logic srcJPend;
  logic srcKPend;

  always_comb begin
    srcJPend = mapValid[instSrcJ] &&
               !(strobe.wrEn && (mapFu[instSrcJ] == strobe.wrFu));
    srcKPend = mapValid[instSrcK] &&
               !(strobe.wrEn && (mapFu[instSrcK] == strobe.wrFu));
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    logic isIssue;
    logic isWrite;
    logic wakeJ;
    logic wakeK;

    assign isIssue = strobe.issueEn && (strobe.issueFu == FU_IW'(u));
    assign isWrite = strobe.wrEn && (strobe.wrFu == FU_IW'(u));
    assign wakeJ   = strobe.wrEn && qjValid[u] && (qj[u] == strobe.wrFu);
    assign wakeK   = strobe.wrEn && qkValid[u] && (qk[u] == strobe.wrFu);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phase[u]   <= PH_IDLE;
        fi[u]      <= '0;
        fj[u]      <= '0;
        fk[u]      <= '0;
        rj[u]      <= 1'b0;
        rk[u]      <= 1'b0;
        qj[u]      <= '0;
        qk[u]      <= '0;
        qjValid[u] <= 1'b0;
        qkValid[u] <= 1'b0;
      end else if (isIssue) begin
        phase[u]   <= PH_READ;
        fi[u]      <= instDst;
        fj[u]      <= instSrcJ;
        fk[u]      <= instSrcK;
        rj[u]      <= !srcJPend;
        rk[u]      <= !srcKPend;
        qj[u]      <= mapFu[instSrcJ];
        qk[u]      <= mapFu[instSrcK];
        qjValid[u] <= srcJPend;
        qkValid[u] <= srcKPend;
      end else if (isWrite) begin
        phase[u] <= PH_IDLE;
      end else if (readGo[u]) begin
        phase[u] <= PH_EXEC;
        rj[u]    <= 1'b0;
        rk[u]    <= 1'b0;
      end else if (doneGo[u]) begin
        phase[u] <= PH_WRITE;
      end else begin
        if (wakeJ) begin
          rj[u]      <= 1'b1;
          qjValid[u] <= 1'b0;
        end
        if (wakeK) begin
          rk[u]      <= 1'b1;
          qkValid[u] <= 1'b0;
        end
      end
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_map
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mapValid[r] <= 1'b0;
        mapFu[r]    <= '0;
      end else if (strobe.issueEn && (instDst == REG_W'(r))) begin
        mapValid[r] <= 1'b1;
        mapFu[r]    <= strobe.issueFu;
      end else if (strobe.wrEn && mapValid[r] && (mapFu[r] == strobe.wrFu)) begin
        mapValid[r] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int unsigned N_INT    = 1,
  parameter int unsigned N_MUL    = 2,
  parameter int unsigned N_ADD    = 1,
  parameter int unsigned N_DIV    = 1,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned NUM_FU  = N_INT + N_MUL + N_ADD + N_DIV,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic              instValid,
  input  logic [2:0]        instOp,
  input  logic [REG_W-1:0]  instDst,
  input  logic [NUM_FU-1:0] execDone,
  input  fuPhase_e          phase [NUM_FU],
  input  logic [REG_W-1:0]  fi [NUM_FU],
  input  logic [REG_W-1:0]  fj [NUM_FU],
  input  logic [REG_W-1:0]  fk [NUM_FU],
  input  logic [NUM_FU-1:0] rj,
  input  logic [NUM_FU-1:0] rk,
  input  logic [NUM_REGS-1:0] mapValid,
  output logic              instAccept,
  output logic [NUM_FU-1:0] readGrant,
  output logic [NUM_FU-1:0] writePermit,
  output logic [NUM_FU-1:0] doneGo,
  output sbStrobe_t         strobe
);

  function automatic fuKind_e unitKind(input int unsigned idx);
    if (idx < N_INT)                      unitKind = KIND_INT;
    else if (idx < N_INT + N_MUL)         unitKind = KIND_MUL;
    else if (idx < N_INT + N_MUL + N_ADD) unitKind = KIND_ADD;
    else                                  unitKind = KIND_DIV;
  endfunction

  fuKind_e          wantKind;
  logic             freeFound;
  logic [FU_IW-1:0] freePick;
  logic             wawHit;

  always_comb begin
    wantKind  = opKind(instOp);
    freeFound = 1'b0;
    freePick  = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (!freeFound && (phase[i] == PH_IDLE) && (unitKind(i) == wantKind)) begin
        freeFound = 1'b1;
        freePick  = FU_IW'(i);
      end
    end
    wawHit     = mapValid[instDst];
    instAccept = instValid && freeFound && !wawHit;
  end

  logic [NUM_FU-1:0] warBlock;
  logic [NUM_FU-1:0] wrReq;

  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      readGrant[i] = (phase[i] == PH_READ) && rj[i] && rk[i];
      doneGo[i]    = execDone[i] && (phase[i] == PH_EXEC);
      warBlock[i]  = 1'b0;
      for (int u = 0; u < NUM_FU; u++) begin
        if ((u != i) && (phase[u] == PH_READ) &&
            (((fj[u] == fi[i]) && rj[u]) || ((fk[u] == fi[i]) && rk[u])))
          warBlock[i] = 1'b1;
      end
      wrReq[i] = (phase[i] == PH_WRITE) && !warBlock[i];
    end
  end

  logic             wrFound;
  logic [FU_IW-1:0] wrPick;

  always_comb begin
    wrFound     = 1'b0;
    wrPick      = '0;
    writePermit = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (!wrFound && wrReq[i]) begin
        wrFound        = 1'b1;
        wrPick         = FU_IW'(i);
        writePermit[i] = 1'b1;
      end
    end
    strobe.issueEn = instAccept;
    strobe.issueFu = freePick;
    strobe.wrEn    = wrFound;
    strobe.wrFu    = wrPick;
  end

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int unsigned N_INT    = 1,
  parameter int unsigned N_MUL    = 2,
  parameter int unsigned N_ADD    = 1,
  parameter int unsigned N_DIV    = 1,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned NUM_FU  = N_INT + N_MUL + N_ADD + N_DIV,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        instOp,
  input  logic [REG_W-1:0]  instDst,
  input  logic [REG_W-1:0]  instSrcJ,
  input  logic [REG_W-1:0]  instSrcK,
  output logic              instAccept,
  output logic [NUM_FU-1:0] readGrant,
  input  logic [NUM_FU-1:0] execDone,
  output logic [NUM_FU-1:0] writePermit
);

  sbStrobe_t         strobe;
  logic [NUM_FU-1:0] doneGo;
  fuPhase_e          phase [NUM_FU];
  logic [REG_W-1:0]  fi [NUM_FU];
  logic [REG_W-1:0]  fj [NUM_FU];
  logic [REG_W-1:0]  fk [NUM_FU];
  logic [NUM_FU-1:0] rj;
  logic [NUM_FU-1:0] rk;
  logic [NUM_REGS-1:0] mapValid;
  logic [FU_IW-1:0]  mapFu [NUM_REGS];

  sb_control #(
    .N_INT(N_INT), .N_MUL(N_MUL), .N_ADD(N_ADD), .N_DIV(N_DIV),
    .NUM_REGS(NUM_REGS)
  ) u_control (
    .instValid  (instValid),
    .instOp     (instOp),
    .instDst    (instDst),
    .execDone   (execDone),
    .phase      (phase),
    .fi         (fi),
    .fj         (fj),
    .fk         (fk),
    .rj         (rj),
    .rk         (rk),
    .mapValid   (mapValid),
    .instAccept (instAccept),
    .readGrant  (readGrant),
    .writePermit(writePermit),
    .doneGo     (doneGo),
    .strobe     (strobe)
  );

  sb_datapath #(
    .NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .readGo  (readGrant),
    .doneGo  (doneGo),
    .instDst (instDst),
    .instSrcJ(instSrcJ),
    .instSrcK(instSrcK),
    .phase   (phase),
    .fi      (fi),
    .fj      (fj),
    .fk      (fk),
    .rj      (rj),
    .rk      (rk),
    .mapValid(mapValid),
    .mapFu   (mapFu)
  );

endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int unsigned NUM_FU = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic              instAccept,
  input logic [NUM_FU-1:0] readGrant,
  input logic [NUM_FU-1:0] writePermit
);

  AST_PERMIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(writePermit)); // R6

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    instAccept |-> instValid); // R1

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (readGrant == '0 && writePermit == '0); // R9
    end
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit_chk
    AST_GRANT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
      readGrant[u] |=> !readGrant[u]); // R4
    AST_PERMIT_FREES: assert property (@(posedge clk) disable iff (!rstN)
      writePermit[u] |=> !writePermit[u]); // R7
    AST_READ_NOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      readGrant[u] |-> !writePermit[u]); // R3
  end

endmodule

bind sb_scoreboard sb_scoreboard_chk #(.NUM_FU(NUM_FU)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instValid  (instValid),
  .instAccept (instAccept),
  .readGrant  (readGrant),
  .writePermit(writePermit)
);

// File: tb/sb_scoreboard_bench.sv
module sb_scoreboard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 5;
  localparam int RW = 4;
  localparam logic [2:0] OP_INT = 3'd0;
  localparam logic [2:0] OP_MUL = 3'd1;
  localparam logic [2:0] OP_ADD = 3'd2;
  localparam logic [2:0] OP_DIV = 3'd4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instValid = 1'b0;
  logic [2:0]    instOp = '0;
  logic [RW-1:0] instDst = '0;
  logic [RW-1:0] instSrcJ = '0;
  logic [RW-1:0] instSrcK = '0;
  logic [NF-1:0] execDone = '0;
  logic          instAccept;
  logic [NF-1:0] readGrant;
  logic [NF-1:0] writePermit;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sb_scoreboard u_sb_scoreboard (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instDst(instDst), .instSrcJ(instSrcJ), .instSrcK(instSrcK),
    .instAccept(instAccept), .readGrant(readGrant), .execDone(execDone),
    .writePermit(writePermit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tryIssue(input logic [2:0] op, input int d, input int j, input int k,
                          input logic exp, input string req);
    instValid = 1'b1;
    instOp    = op;
    instDst   = RW'(d);
    instSrcJ  = RW'(j);
    instSrcK  = RW'(k);
    #1;
    chk(req, 32'(instAccept), 32'(exp));
    step();
    instValid = 1'b0;
  endtask

  task automatic pulseDone(input logic [NF-1:0] mask);
    execDone = mask;
    step();
    execDone = '0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int caps [4];
    logic [2:0] ops [4];
    int base;
    caps = '{1, 2, 1, 1};
    ops  = '{OP_INT, OP_MUL, OP_ADD, OP_DIV};
    repeat (3) @(negedge clk);
    chk("R9 grant in reset", 32'(readGrant), 0);
    chk("R9 permit in reset", 32'(writePermit), 0);
    rstN = 1'b1;
    #1;
    chk("R9 accept idle", 32'(instAccept), 0);
    chk("R9 permit after reset", 32'(writePermit), 0);

    // Basic flow through the integer unit
    tryIssue(OP_INT, 1, 2, 3, 1'b1, "R1 basic issue");
    chk("R3 grant free sources", 32'(readGrant), 32'h01);
    step();
    chk("R4 executing no grant", 32'(readGrant), 0);
    pulseDone(5'b00001);
    chk("R4 write after done", 32'(writePermit), 32'h01);
    step();
    chk("R7 unit freed", 32'(writePermit), 0);

    // Structural sweep over every unit kind
    base = 1;
    for (int kd = 0; kd < 4; kd++) begin
      for (int n = 0; n <= caps[kd]; n++)
        tryIssue(ops[kd], base + n, 0, 0, (n < caps[kd]), "R1 capacity");
      base += caps[kd] + 1;
    end
    pulseDone(5'b11111);
    for (int i = 0; i < NF; i++) begin
      chk("R6 lowest index first", 32'(writePermit), 32'(1 << i));
      step();
    end
    chk("R6 all written", 32'(writePermit), 0);

    // WAW stall
    tryIssue(OP_MUL, 5, 0, 0, 1'b1, "R2 first writer");
    tryIssue(OP_ADD, 5, 0, 0, 1'b0, "R2 waw stall");
    pulseDone(5'b00010);
    chk("R4 mul permit", 32'(writePermit), 32'h02);
    step();
    tryIssue(OP_ADD, 5, 0, 0, 1'b1, "R2 after write");
    step();
    pulseDone(5'b01000);
    chk("R4 add permit", 32'(writePermit), 32'h08);
    step();

    // RAW wait plus WAR hold
    tryIssue(OP_MUL, 0, 1, 2, 1'b1, "R1 mul");
    tryIssue(OP_DIV, 10, 0, 6, 1'b1, "R1 div");
    tryIssue(OP_ADD, 6, 8, 2, 1'b1, "R1 add");
    chk("R3 div waits raw", 32'(readGrant), 32'h08);
    step();
    pulseDone(5'b01000);
    chk("R5 war hold", 32'(writePermit), 0);
    step();
    chk("R5 war still held", 32'(writePermit), 0);
    pulseDone(5'b00010);
    chk("R3 div still waiting", 32'(readGrant), 0);
    chk("R5 producer writes", 32'(writePermit), 32'h02);
    step();
    chk("R7 wake div", 32'(readGrant), 32'h10);
    chk("R5 held until read", 32'(writePermit), 0);
    step();
    chk("R5 released after read", 32'(writePermit), 32'h08);
    step();
    pulseDone(5'b10000);
    chk("R4 div permit", 32'(writePermit), 32'h10);
    step();

    // Issue in the same cycle as the source's producer writes
    tryIssue(OP_MUL, 3, 0, 0, 1'b1, "R1 producer");
    step();
    pulseDone(5'b00010);
    chk("R8 producer permit", 32'(writePermit), 32'h02);
    tryIssue(OP_INT, 9, 3, 3, 1'b1, "R8 same cycle issue");
    chk("R8 bypassed ready", 32'(readGrant), 32'h01);
    step();
    pulseDone(5'b00001);
    step();

    // Completion pulses on units not executing
    pulseDone(5'b11111);
    chk("R4 idle done ignored", 32'(writePermit), 0);
    tryIssue(OP_MUL, 13, 0, 0, 1'b1, "R1 mul");
    tryIssue(OP_ADD, 12, 13, 0, 1'b1, "R1 add dep");
    pulseDone(5'b01000);
    chk("R4 waiting done ignored", 32'(writePermit), 0);
    pulseDone(5'b00010);
    chk("R4 mul permit", 32'(writePermit), 32'h02);
    step();
    chk("R7 add woken", 32'(readGrant), 32'h08);
    step();
    pulseDone(5'b01000);
    chk("R4 add executes normally", 32'(writePermit), 32'h08);
    step();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule